// File: doc/BRIEF.md
# Oscillator clock controller with timebase and tone output

This peripheral sits beside an 8-bit processor core and runs entirely from the oscillator clock. It has three independent functions that share a single control register:

- **CPU clock prescaler.** It produces a single-cycle clock enable for the CPU and its peripherals. The enable can follow the oscillator at full rate, or a slow divided rate.
- **Clock-out pin.** It reflects the CPU clock ticks on an output pin.
- **Periodic timebase.** A 12-bit counter behind a divide-by-64 pre-stage raises an overflow flag and an interrupt once per selectable period. When the interrupt is enabled, a halt request puts the device into an active-halt state. The timebase keeps running in that state, and its interrupt ends it.

A second register selects the tone of a square-wave beeper.

Software writes either register through a one-cycle write strobe with a one-bit address. Software reads the control register through a read strobe, and that read clears the overflow flag. Every output is a function of registered state only. A write therefore shows on the outputs one clock after its strobe.

Top module: `osc_clock_ctrl`

## Requirements
- R1: After reset the control register reads 0, the interrupt, beeper, clock-out and active-halt outputs are low, and the CPU enable is high on every cycle.
- R2: The control register (address 0) holds these fields:
  - bit 0: slow-mode select
  - bits 2:1: slow divider code
  - bits 4:3: timebase code
  - bit 5: interrupt enable
  - bit 6: overflow flag (read-only, ignored on write)
  - bit 7: clock-out enable

  `rd_data` always shows these fields.
- R3: With slow mode off, `cpu_ce` is high on every cycle. With slow mode on and divider code n, `cpu_ce` pulses for one cycle every 2^(n+1) cycles.
- R4: A change of the slow-mode bit or the divider code takes effect only at the next `cpu_ce` pulse of the setting in force, so no divided period is shortened.
- R5: Timebase codes 0, 1, 2 and 3 give periods of 16000, 32000, 80000 and 200000 oscillator cycles. At the end of each period the overflow flag is set.
- R6: Every write to the control register restarts the timebase period from zero. A period end that falls on the write cycle is discarded.
- R7: A read strobe clears the overflow flag, except when a period ends in the same cycle, in which case the flag stays set. `tb_irq` is high exactly while both the flag and the interrupt enable are 1.
- R8: A halt request sets `active_halt` one cycle later only if the interrupt enable is 1 and `tb_irq` is low. While `active_halt` is high, `cpu_ce` is low. `active_halt` clears the cycle after `tb_irq` is seen high.
- R9: With clock-out enabled, `clk_out` toggles after each `cpu_ce` pulse and holds its level during active-halt. With clock-out disabled, `clk_out` goes low.
- R10: Beeper code (address 1, bits 1:0) 0 holds `beep_out` low. Codes 1, 2 and 3 give 50% duty square waves of period 4096, 2048 and 1024 cycles.
- R11: A write to the beeper register restarts the tone phase, so the output is low for the first half period after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control register, 1 = beeper register |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Control register read strobe (clears overflow flag) |
| rd_data | output | 8 | Control register contents |
| halt_req | input | 1 | Request to enter halt |
| cpu_ce | output | 1 | CPU and peripheral clock enable |
| clk_out | output | 1 | Clock-out pin level |
| tb_irq | output | 1 | Timebase interrupt |
| beep_out | output | 1 | Beeper pin |
| active_halt | output | 1 | Device is in active-halt |

## Verification
All outputs come from registers. A register write therefore changes `rd_data`, the clock-out level and the beeper code in the cycle after the strobe. A prescaler setting shows only after the current divided period has finished. The overflow flag and `tb_irq` rise one cycle after the last oscillator cycle of a period; a read clears them one cycle after the strobe, and active-halt is entered or left one cycle after its cause. The bench keeps an integer reference model that advances on each rising edge from the same inputs. It compares every output against that model on each falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

  typedef struct packed {
    logic       clkout_en;
    logic       ovf_flag;
    logic       ovf_ie;
    logic [1:0] tb_sel;
    logic [1:0] cpu_div;
    logic       slow_sel;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // Divided-clock length in oscillator cycles for a divider code.
  function automatic int unsigned cpu_div_len(input logic [1:0] code);
    return 32'd2 << code;
  endfunction

  // Number of pre-divider wraps that make one timebase period.
  function automatic int unsigned tb_limit(input logic [1:0] code);
    case (code)
      2'd0:    return 250;
      2'd1:    return 500;
      2'd2:    return 1250;
      default: return 3125;
    endcase
  endfunction

  // Counter bit that forms the square wave for a tone code (1..3).
  function automatic int unsigned beep_tap(input int unsigned width, input logic [1:0] code);
    return width - 32'(code);
  endfunction

endpackage

// File: rtl/clkctl_prescaler.sv
module clkctl_prescaler
  import clkctl_pkg::*;
#(
  parameter int PS_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sms_req,
  input  logic [1:0] cp_req,
  input  logic       halt,
  output logic       boundary,
  output logic       ce
);

  logic [PS_W-1:0] phase_q;
  logic            slow_q;
  logic [1:0]      cp_q;
  logic [PS_W-1:0] phase_last;

  assign phase_last = PS_W'(cpu_div_len(cp_q) - 1);
  assign boundary   = !slow_q || (phase_q == phase_last);
  assign ce         = boundary && !halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      slow_q  <= 1'b0;
      cp_q    <= 2'd0;
    end else if (boundary) begin
      phase_q <= '0;
      slow_q  <= sms_req;
      cp_q    <= cp_req;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  // Slow setting applied at a boundary leaves a gap of at least one cycle
  assert_slow_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && sms_req) |=> !boundary);

  // Settings only move at boundaries
  assert_hold_setting_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(slow_q) && $stable(cp_q)));

endmodule

// File: rtl/clkctl_timebase.sv
module clkctl_timebase
  import clkctl_pkg::*;
#(
  parameter int PRE_W = 6,
  parameter int CNT_W = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] tb_sel,
  output logic       period_end
);

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_last;
  logic             pre_wrap;
  logic             cnt_wrap;

  assign cnt_last   = CNT_W'(tb_limit(tb_sel) - 1);
  assign pre_wrap   = &pre_q;
  assign cnt_wrap   = (cnt_q == cnt_last);
  assign period_end = pre_wrap && cnt_wrap && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (pre_wrap) cnt_q <= cnt_wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cnt_last);

  assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && pre_q == '0));

endmodule

// File: rtl/clkctl_beeper.sv
module clkctl_beeper
  import clkctl_pkg::*;
#(
  parameter int BW = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart,
  input  logic [1:0] tone_next,
  output logic       beep
);

  localparam int IDX_W = $clog2(BW);

  logic [BW-1:0]    cnt_q;
  logic [1:0]       tone_q;
  logic [IDX_W-1:0] tap;

  assign tap  = (tone_q == 2'd0) ? '0 : IDX_W'(beep_tap(BW, tone_q));
  assign beep = (tone_q != 2'd0) && cnt_q[tap];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tone_q <= 2'd0;
    end else if (restart) begin
      cnt_q  <= '0;
      tone_q <= tone_next;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assert_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_q == 2'd0) |-> !beep);

  assert_phase_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !beep);

endmodule

// File: rtl/osc_clock_ctrl.sv
module osc_clock_ctrl
  import clkctl_pkg::*;
#(
  parameter int PS_W    = 4,
  parameter int PRE_W   = 6,
  parameter int TB_W    = 12,
  parameter int BEEP_W  = 12
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  input  logic       halt_req,
  output logic       cpu_ce,
  output logic       clk_out,
  output logic       tb_irq,
  output logic       beep_out,
  output logic       active_halt
);

  ctrl_t ctrl_q;
  ctrl_t wr_view;
  logic  halt_q;
  logic  clk_out_q;
  logic  wr_ctrl;
  logic  wr_beep;
  logic  period_end;
  logic  div_boundary;
  logic  unused_bits;

  assign wr_view     = ctrl_t'(wr_data);
  assign wr_ctrl     = wr_en && !wr_addr;
  assign wr_beep     = wr_en && wr_addr;
  assign unused_bits = wr_view.ovf_flag;

  // Control register; the flag bit is owned by the timebase logic
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.clkout_en <= wr_view.clkout_en;
        ctrl_q.ovf_ie    <= wr_view.ovf_ie;
        ctrl_q.tb_sel    <= wr_view.tb_sel;
        ctrl_q.cpu_div   <= wr_view.cpu_div;
        ctrl_q.slow_sel  <= wr_view.slow_sel;
      end
      if (period_end)  ctrl_q.ovf_flag <= 1'b1;
      else if (rd_en)  ctrl_q.ovf_flag <= 1'b0;
    end
  end

  assign rd_data = CTRL_W'(ctrl_q);
  assign tb_irq  = ctrl_q.ovf_flag && ctrl_q.ovf_ie;

  // Active-halt state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                        halt_q <= 1'b0;
    else if (halt_q && tb_irq)                         halt_q <= 1'b0;
    else if (halt_req && ctrl_q.ovf_ie && !tb_irq)     halt_q <= 1'b1;
  end
  assign active_halt = halt_q;

  clkctl_prescaler #(.PS_W(PS_W)) u_prescaler (
    .clk      (clk),
    .rst_n    (rst_n),
    .sms_req  (ctrl_q.slow_sel),
    .cp_req   (ctrl_q.cpu_div),
    .halt     (halt_q),
    .boundary (div_boundary),
    .ce       (cpu_ce)
  );

  // Clock-out pin follows CPU ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 clk_out_q <= 1'b0;
    else if (!ctrl_q.clkout_en) clk_out_q <= 1'b0;
    else if (cpu_ce)            clk_out_q <= !clk_out_q;
  end
  assign clk_out = clk_out_q;

  clkctl_timebase #(.PRE_W(PRE_W), .CNT_W(TB_W)) u_timebase (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (wr_ctrl),
    .tb_sel     (ctrl_q.tb_sel),
    .period_end (period_end)
  );

  clkctl_beeper #(.BW(BEEP_W)) u_beeper (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (wr_beep),
    .tone_next (wr_data[1:0]),
    .beep      (beep_out)
  );

  logic unused_boundary;
  assign unused_boundary = div_boundary;

  assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> ctrl_q.ovf_flag);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !period_end) |=> !ctrl_q.ovf_flag);

  assert_halt_enter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && ctrl_q.ovf_ie && !tb_irq) |=> active_halt);

  assert_halt_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (active_halt && tb_irq) |=> !active_halt);

  assert_halt_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    active_halt |-> !cpu_ce);

  assert_clkout_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_halt && ctrl_q.clkout_en) |=> $stable(clk_out));

  assert_clkout_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.clkout_en |=> !clk_out);

endmodule

// File: tb/osc_clock_ctrl_tb.sv
module osc_clock_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic       halt_req = 1'b0;
  logic [7:0] rd_data;
  logic       cpu_ce, clk_out, tb_irq, beep_out, active_halt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  osc_clock_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .halt_req(halt_req), .cpu_ce(cpu_ce),
    .clk_out(clk_out), .tb_irq(tb_irq), .beep_out(beep_out), .active_halt(active_halt)
  );

  // ---------------- behavioural reference model ----------------
  bit [7:0] m_ctrl;
  bit       m_flag, m_slow, m_halt, m_co;
  int       m_len, m_phase, m_ticks, m_bticks;
  bit [1:0] m_bc;

  function automatic int period_of(input bit [1:0] code);
    case (code)
      2'd0: return 16000;
      2'd1: return 32000;
      2'd2: return 80000;
      default: return 200000;
    endcase
  endfunction

  function automatic bit m_exp_ce();
    return !m_halt && (!m_slow || m_phase == m_len - 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 8'h00; m_flag = 0; m_slow = 0; m_halt = 0; m_co = 0;
      m_len = 2; m_phase = 0; m_ticks = 0; m_bticks = 0; m_bc = 2'd0;
    end else begin
      bit ce_o, bnd, irq_o, wc, wb, end_o;
      ce_o  = m_exp_ce();
      bnd   = !m_slow || (m_phase == m_len - 1);
      irq_o = m_flag && m_ctrl[5];
      wc    = wr_en && !wr_addr;
      wb    = wr_en && wr_addr;
      end_o = !wc && (m_ticks == period_of(m_ctrl[4:3]) - 1);
      if (bnd) begin
        m_slow = m_ctrl[0]; m_len = 2 << m_ctrl[2:1]; m_phase = 0;
      end else m_phase++;
      if (!m_ctrl[7]) m_co = 0; else if (ce_o) m_co = !m_co;
      m_ticks = (wc || end_o) ? 0 : m_ticks + 1;
      if (end_o) m_flag = 1; else if (rd_en) m_flag = 0;
      if (m_halt && irq_o) m_halt = 0;
      else if (halt_req && m_ctrl[5] && !irq_o) m_halt = 1;
      if (wb) begin m_bticks = 0; m_bc = wr_data[1:0]; end
      else m_bticks = (m_bticks + 1) % 4096;
      if (wc) m_ctrl = wr_data & 8'hBF;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare every output on each falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit eb;
      eb = (m_bc != 0) && (((m_bticks / (4096 >> m_bc)) % 2) == 1);
      check(cpu_ce == m_exp_ce(), "R3/R4 cpu_ce", cpu_ce, m_exp_ce());
      check(clk_out == m_co, "R9 clk_out", clk_out, m_co);
      check(tb_irq == (m_flag && m_ctrl[5]), "R5/R6/R7 tb_irq", tb_irq, m_flag && m_ctrl[5]);
      check(rd_data == (m_ctrl | (8'(m_flag) << 6)), "R2/R5/R6/R7 rd_data", rd_data,
            m_ctrl | (8'(m_flag) << 6));
      check(beep_out == eb, "R10/R11 beep_out", beep_out, eb);
      check(active_halt == m_halt, "R8 active_halt", active_halt, m_halt);
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_reg(input bit a, input bit [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0; wr_data = 8'h00;
  endtask

  task automatic read_ctrl();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse_halt();
    @(negedge clk); halt_req = 1;
    @(negedge clk); halt_req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check(rd_data == 8'h00, "R1 rd_data", rd_data, 0);
    check(!tb_irq && !beep_out && !clk_out && !active_halt, "R1 outputs low",
          {tb_irq, beep_out, clk_out, active_halt}, 0);
    check(cpu_ce == 1'b1, "R1 cpu_ce", cpu_ce, 1);
    idle(20);
    // R9 clock-out in fast mode, then each slow divider (R3)
    write_reg(0, 8'h80); idle(20);
    write_reg(0, 8'h81); idle(20);
    write_reg(0, 8'h83); idle(30);
    write_reg(0, 8'h85); idle(50);
    write_reg(0, 8'h87); idle(5);
    // R4: change mid-period, applies at next divided boundary
    write_reg(0, 8'h81); idle(40);
    write_reg(0, 8'h85); idle(3);
    write_reg(0, 8'h80); idle(30);
    write_reg(0, 8'h00); idle(10);
    // R10/R11 tones, restart of phase mid-tone
    write_reg(1, 8'h01); idle(9000);
    write_reg(1, 8'h02); idle(3000);
    write_reg(1, 8'h02); idle(2100);
    write_reg(1, 8'h03); idle(2100);
    write_reg(1, 8'h00); idle(100);
    // R8: halt without interrupt enable is ignored
    pulse_halt(); idle(5);
    // R5/R7: timebase code 0 with interrupt, read to clear
    write_reg(0, 8'h20); idle(16010);
    read_ctrl(); idle(10);
    // R8/R9: active-halt with clock-out and slow clock, woken by timebase
    write_reg(0, 8'hA3); pulse_halt(); idle(16050);
    read_ctrl(); idle(5);
    // R6: restart mid-period
    write_reg(0, 8'h20); idle(5000);
    write_reg(0, 8'h20); idle(16100);
    // R7: read in the same cycle as a period end keeps the flag
    write_reg(0, 8'h20); idle(15998);
    @(negedge clk); rd_en = 1; @(negedge clk); rd_en = 0; idle(20);
    read_ctrl();
    // R5: longer periods
    write_reg(0, 8'h28); idle(32100);
    write_reg(0, 8'h30); idle(20000);
    write_reg(0, 8'h38); idle(15000);
    finish_run();
  end

endmodule